// File: doc/BRIEF.md
# Selectable-Timebase 16-bit Counter

This block is a free-running 16-bit up-counter. Each cycle it counts or holds according to a single count-enable. An 8-bit mode register picks the source of that enable from six choices: two fixed divisions of the system clock, the undivided system clock, an overflow strobe from a neighbouring timer, falling edges on an external count pin, or an external oscillator. The oscillator is divided by eight in its own domain and then brought into the system clock domain.

A second mode bit lets the counter freeze while the chip reports idle. When the counter rolls over, it sets a sticky overflow flag. An interrupt request follows that flag only when the enable bit in the mode register is set. Software writes the mode register through a one-cycle write strobe and reads it back as a plain byte. All pins are plain level or pulse controls; the block has no streamed data path, so there is no valid/ready handshake.

Top module: `cnt_tbsel`

## Requirements
- R1: After reset the count is 0x0000, the overflow flag and the interrupt output are low, and the mode register reads 0x00: idle control off, select 000, interrupt masked.
- R2: Select 000 advances the count by one every 12 system clock cycles, so any 120-cycle window adds exactly 10.
- R3: Select 001 advances the count by one every 4 system clock cycles.
- R4: Select 100 advances the count by one on every system clock cycle.
- R5: Select 010 advances the count by one for each system clock cycle in which the timer overflow input is high.
- R6: Select 011 advances the count by one per high-to-low transition on the external count pin. The pin passes through a 2-flop synchronizer, must hold each level for at least 2 cycles, and is counted at no more than the system clock rate divided by 4.
- R7: Select 101 advances the count by one per 8 cycles of the external oscillator. The division is done in the oscillator domain, and the result is synchronized before use.
- R8: The reserved selects 110 and 111 produce no count enable, so the count holds.
- R9: Mode bit 7 set with the idle input high suspends counting. With bit 7 clear, the idle input has no effect.
- R10: The mode register takes a write on the clock edge where cfg_wr is high. It reads back as {bit7 idle control, 3'b000, bits3:1 select, bit0 interrupt enable}. Writes to bits 6:4 are ignored.
- R11: A wrap from 0xFFFF to 0x0000 sets the overflow flag. The flag stays set until flag_clr is high at a clock edge. A wrap in the same cycle as a clear wins over the clear.
- R12: The interrupt output equals the overflow flag ANDed with mode bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| cfg_rdata | output | 8 | Mode register read data |
| tmr_ovf | input | 1 | Overflow strobe from the neighbouring timer |
| ext_cnt_in | input | 1 | External count pin, counted on falling edges |
| ext_osc | input | 1 | External oscillator |
| idle | input | 1 | System idle indication |
| flag_clr | input | 1 | Clears the overflow flag |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked overflow interrupt request |

## Verification
The bench measures count deltas over windows whose length is a multiple of each divider period. A divider that is off by one therefore shows up as a wrong total rather than as a phase shift.

It toggles the external pin at legal widths to catch a missing synchronizer or an edge detector that fires on both edges, which would double the count. It drives the reserved selects and the idle suspend to catch a counter that keeps running when it should hold.

Near the rollover it checks that the flag rises exactly on the wrap, that it sticks with a masked interrupt, and that the interrupt rises once the enable bit is written. A flag wired as a pulse, or an interrupt that ignores its mask, fails these checks.

// File: rtl/cnt_tbsel_pkg.sv
package cnt_tbsel_pkg;
  typedef enum logic [2:0] {
    SEL_DIV12 = 3'b000,
    SEL_DIV4  = 3'b001,
    SEL_TMR   = 3'b010,
    SEL_PIN   = 3'b011,
    SEL_SYS   = 3'b100,
    SEL_OSC   = 3'b101,
    SEL_RSV6  = 3'b110,
    SEL_RSV7  = 3'b111
  } tb_sel_e;
endpackage

// File: rtl/tbsel_divider.sv
module tbsel_divider #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  // tick lasts one cycle (supports R2, R3)
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tbsel_pin_edge.sv
module tbsel_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

  // one enable pulse per detected falling edge
  assert_fall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tbsel_osc_div.sv
module tbsel_osc_div #(
  parameter int OSC_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc,
  output logic tick
);
  localparam int W = $clog2(OSC_DIV);

  logic [W-1:0]           div_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // divider runs in the oscillator domain
  always_ff @(posedge osc or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], div_q[W-1]};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign tick = sync_q[SYNC_STAGES-1] & ~prev_q;

  assert_osc_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/cnt_tbsel.sv
module cnt_tbsel
  import cnt_tbsel_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int OSC_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             tmr_ovf,
  input  logic             ext_cnt_in,
  input  logic             ext_osc,
  input  logic             idle,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  tb_sel_e          sel_q;
  logic             idle_ctl_q;
  logic             ie_q;
  logic [CNT_W-1:0] count_q;
  logic             flag_q;
  logic             tick_slow, tick_fast, pin_fall, osc_tick;
  logic             raw_en, run, wrap;
  logic [2:0]       unused_wbits;

  assign unused_wbits = cfg_wdata[6:4];

  tbsel_divider #(.DIV(DIV_SLOW)) u_div_slow (.clk(clk), .rst_n(rst_n), .tick(tick_slow));
  tbsel_divider #(.DIV(DIV_FAST)) u_div_fast (.clk(clk), .rst_n(rst_n), .tick(tick_fast));

  tbsel_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin(ext_cnt_in), .fall(pin_fall));

  tbsel_osc_div #(.OSC_DIV(OSC_DIV), .SYNC_STAGES(SYNC_STAGES)) u_osc (
    .clk(clk), .rst_n(rst_n), .osc(ext_osc), .tick(osc_tick));

  // mode register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= SEL_DIV12;
      idle_ctl_q <= 1'b0;
      ie_q       <= 1'b0;
    end else if (cfg_wr) begin
      sel_q      <= tb_sel_e'(cfg_wdata[3:1]);
      idle_ctl_q <= cfg_wdata[7];
      ie_q       <= cfg_wdata[0];
    end
  end

  assign cfg_rdata = {idle_ctl_q, 3'b000, sel_q, ie_q};

  // timebase selection
  always_comb begin
    case (sel_q)
      SEL_DIV12: raw_en = tick_slow;
      SEL_DIV4:  raw_en = tick_fast;
      SEL_TMR:   raw_en = tmr_ovf;
      SEL_PIN:   raw_en = pin_fall;
      SEL_SYS:   raw_en = 1'b1;
      SEL_OSC:   raw_en = osc_tick;
      default:   raw_en = 1'b0;
    endcase
  end

  assign run  = raw_en & ~(idle_ctl_q & idle);
  assign wrap = run & (count_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (run) count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign count    = count_q;
  assign ovf_flag = flag_q;
  assign irq      = flag_q & ie_q;

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> (count_q == $past(count_q) + 1'b1));

  assert_reserved_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == SEL_RSV6 || sel_q == SEL_RSV7) |=> $stable(count_q));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ctl_q && idle) |=> $stable(count_q));

  assert_wrap_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CNT_MAX && run) |=> (ovf_flag && count_q == '0));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q && !cfg_wr) |=> !irq);
endmodule

// File: tb/tb_cnt_tbsel.sv
module tb_cnt_tbsel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        tmr_ovf = 1'b0;
  logic        ext_cnt_in = 1'b1;
  logic        ext_osc = 1'b0;
  logic        idle = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] count;
  logic        ovf_flag;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;
  always #14 ext_osc = ~ext_osc;

  cnt_tbsel dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tmr_ovf(tmr_ovf), .ext_cnt_in(ext_cnt_in),
    .ext_osc(ext_osc), .idle(idle), .flag_clr(flag_clr), .count(count),
    .ovf_flag(ovf_flag), .irq(irq));

  // {mode[7:0], idle, cycles[15:0], expected delta[15:0]}
  localparam int NV = 10;
  localparam logic [40:0] VEC [NV] = '{
    {8'h00, 1'b0, 16'd120, 16'd10},   // R2 div 12
    {8'h02, 1'b0, 16'd120, 16'd30},   // R3 div 4
    {8'h08, 1'b0, 16'd120, 16'd120},  // R4 sysclk
    {8'h88, 1'b1, 16'd120, 16'd0},    // R9 suspended
    {8'h08, 1'b1, 16'd120, 16'd120},  // R9 idle ignored
    {8'h0C, 1'b0, 16'd120, 16'd0},    // R8 code 110
    {8'h0E, 1'b0, 16'd120, 16'd0},    // R8 code 111
    {8'h04, 1'b0, 16'd120, 16'd0},    // R5 no strobes
    {8'h80, 1'b0, 16'd120, 16'd10},   // R9 control set, not idle
    {8'h72, 1'b0, 16'd120, 16'd30}    // R10 unused bits ignored
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", 32'(count), 32'h0);
    chk("R1 flag", 32'(ovf_flag), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 mode", 32'(cfg_rdata), 32'h00);

    wr_mode(8'hFF);
    chk("R10 readback", 32'(cfg_rdata), 32'h8F);

    for (int i = 0; i < NV; i++) begin
      wr_mode(VEC[i][40:33]);
      idle = VEC[i][32];
      repeat (20) @(negedge clk);
      c0 = count;
      repeat (int'(VEC[i][31:16])) @(negedge clk);
      chk($sformatf("R2-table vec %0d (R3 R4 R8 R9 R10)", i),
          32'(count - c0), 32'(VEC[i][15:0]));
    end
    idle = 1'b0;

    // R5 timer strobe
    wr_mode(8'h04);
    repeat (4) @(negedge clk);
    c0 = count;
    for (int k = 0; k < 7; k++) begin
      tmr_ovf = 1'b1;
      @(negedge clk);
      tmr_ovf = 1'b0;
      repeat (2) @(negedge clk);
    end
    chk("R5 timer strobes", 32'(count - c0), 32'd7);

    // R6 external pin falling edges
    wr_mode(8'h06);
    repeat (6) @(negedge clk);
    c0 = count;
    for (int k = 0; k < 5; k++) begin
      ext_cnt_in = 1'b0;
      repeat (3) @(negedge clk);
      ext_cnt_in = 1'b1;
      repeat (3) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk("R6 pin edges", 32'(count - c0), 32'd5);

    // R7 oscillator / 8: 560 cycles = 400 osc periods
    wr_mode(8'h0A);
    repeat (20) @(negedge clk);
    c0 = count;
    repeat (560) @(negedge clk);
    n_chk++;
    if ((count - c0) < 16'd49 || (count - c0) > 16'd51) begin
      n_fail++;
      $display("FAIL R7 osc div: actual %0d expected 50 +/-1", count - c0);
    end

    // R11 / R12 overflow
    wr_mode(8'h08);
    for (int k = 0; k < 70000 && count != 16'hFFFF; k++) @(negedge clk);
    chk("R11 before wrap count", 32'(count), 32'hFFFF);
    chk("R11 flag before wrap", 32'(ovf_flag), 32'h0);
    @(negedge clk);
    chk("R11 wrapped count", 32'(count), 32'h0);
    chk("R11 flag on wrap", 32'(ovf_flag), 32'h1);
    chk("R12 irq masked", 32'(irq), 32'h0);
    wr_mode(8'h0D);
    chk("R12 irq enabled", 32'(irq), 32'h1);
    repeat (5) @(negedge clk);
    chk("R11 flag sticky", 32'(ovf_flag), 32'h1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R11 flag cleared", 32'(ovf_flag), 32'h0);
    chk("R12 irq after clear", 32'(irq), 32'h0);

    finish_run();
  end
endmodule